// File: doc/BRIEF.md
# Two-Level Address Translation Walker

This block turns a 32-bit device virtual address into a physical address by reading a two-level translation table held in memory. A caller presents one lookup at a time. Each lookup carries the virtual address, the base of the first-level table and a code that selects the length of that table. The walker fetches the first-level descriptor over a simple word-read port. Depending on the descriptor type it either finishes at once with a 1 MiB section, or fetches one second-level descriptor and finishes with a 64 KiB or 4 KiB page. Any descriptor marked as unmapped ends the lookup in a fault.

The result comes back as a single-cycle completion pulse. The pulse carries the physical address, a fault flag and a code for the page size that produced the translation. A virtual address that lies outside the configured table length faults straight away, with no memory access. The read port has one request in flight at most. Each request is a one-cycle pulse with a word address, and memory answers later with a one-cycle data-valid pulse.

Top module: `xlat_walker`

## Requirements
- R1: After a synchronous active-low reset, and after a reset applied in the middle of a walk, req_ready is 1 and done and mem_req are 0. A read answered after such a reset produces no done pulse.
- R2: The first read of a walk goes to (req_base with its low log2(table bytes) bits cleared) OR (VA[31:20] shifted left by 2). The table size is 8192 >> req_sel bytes for req_sel from 0 to 6, so 8192, 4096, 2048, 1024, 512, 256 or 128 bytes.
- R3: When VA[31:20] is at or above 2048 >> req_sel, or when req_sel is 7, the lookup completes with done_fault = 1 and issues no memory read.
- R4: A first-level descriptor with bits [1:0] = 2'b10 completes the lookup with done_pa = {desc[31:20], VA[19:0]} and done_size = 2.
- R5: A first-level descriptor with bits [1:0] = 2'b01 causes exactly one second read, at address {desc[31:10], VA[19:12], 2'b00}.
- R6: A second-level descriptor with bits [1:0] = 2'b10 completes with done_pa = {desc[31:12], VA[11:0]} and done_size = 0.
- R7: A second-level descriptor with bits [1:0] = 2'b01 completes with done_pa = {desc[31:16], VA[15:0]} and done_size = 1, whatever the value of VA[15:12] within the 64 KiB page.
- R8: A descriptor whose bits [1:0] are 2'b00, or 2'b11, at either level completes the lookup with done_fault = 1, done_pa = 0 and done_size = 0.
- R9: req_ready is 0 from the cycle after a request is accepted until the done pulse. A req_valid asserted while req_ready is 0 starts no walk and does not change the result. mem_req is high for one cycle at a time and is never raised while a read is outstanding.
- R10: A mem_rvalid pulse that arrives while no read is outstanding produces no done pulse and no memory read.
- R11: done is a single-cycle pulse. It rises in the cycle after the mem_rvalid that delivers the final descriptor, or in the cycle after acceptance when the lookup faults on range.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Lookup request; accepted when req_ready is 1 |
| req_ready | output | 1 | High when idle and able to accept a lookup |
| req_va | input | 32 | Virtual address to translate |
| req_base | input | 32 | First-level table base address |
| req_sel | input | 3 | Table size code: 8192 >> req_sel bytes; 7 is invalid |
| mem_req | output | 1 | One-cycle word read request |
| mem_addr | output | 32 | Word address of the read, valid with mem_req |
| mem_rvalid | input | 1 | One-cycle read data valid |
| mem_rdata | input | 32 | Read data, valid with mem_rvalid |
| done | output | 1 | One-cycle completion pulse |
| done_pa | output | 32 | Physical address, 0 on fault |
| done_fault | output | 1 | Lookup ended in a fault |
| done_size | output | 2 | Page size: 0 = 4 KiB, 1 = 64 KiB, 2 = 1 MiB |

## Verification
If the walk state is corrupted, the fault shows at the ports within one read latency. A second read appears where none was due, an expected read is missing, or the done pulse arrives late, twice or never. A wrong captured address or a wrong offset field shows in done_pa on the very pulse that ends the walk, because the offset bits come straight from the held virtual address. A wrong table mask shows as a wrong mem_addr on the first read, one cycle after acceptance, before any data returns.

// File: rtl/xw_pkg.sv
// Shared constants and types for the translation walker.
// Assumes 32-bit addresses and a 32-bit descriptor word.
package xw_pkg;
    localparam int ADDR_W        = 32;
    localparam int SECT_SHIFT    = 20;   // first-level index starts here
    localparam int L2_BASE_SHIFT = 10;   // second-level tables are 1 KiB aligned
    localparam int LARGE_SHIFT   = 16;   // 64 KiB page offset width
    localparam int SMALL_SHIFT   = 12;   // 4 KiB page offset width

    typedef enum logic [1:0] {
        PG_4K  = 2'd0,
        PG_64K = 2'd1,
        PG_1M  = 2'd2
    } pg_size_e;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_L1_WAIT = 2'd1,
        ST_L2_WAIT = 2'd2
    } walk_st_e;

    typedef enum logic [1:0] {
        DK_FAULT = 2'd0,
        DK_LEAF  = 2'd1,
        DK_NEXT  = 2'd2
    } desc_kind_e;

    // addr is the physical address for a leaf, the next read address for a
    // table pointer, and zero for a fault
    typedef struct packed {
        desc_kind_e          kind;
        pg_size_e            size;
        logic [ADDR_W-1:0]   addr;
    } desc_res_t;
endpackage

// File: rtl/xw_l1_locate.sv
// First-level locator: checks the virtual address against the configured
// table length and forms the first-level descriptor address.
// Assumes sizes are powers of two from MIN_ENT to MAX_ENT entries, and that
// the size code selects MAX_ENT >> code entries.
module xw_l1_locate
    import xw_pkg::*;
#(
    parameter int MAX_ENT = 2048,
    parameter int MIN_ENT = 32,
    parameter int SEL_W   = 3
) (
    input  logic [ADDR_W-1:0] va_i,
    input  logic [ADDR_W-1:0] base_i,
    input  logic [SEL_W-1:0]  sel_i,
    output logic              in_range_o,
    output logic [ADDR_W-1:0] l1_addr_o
);
    localparam int IDX_W     = ADDR_W - SECT_SHIFT;
    localparam int NSIZES    = $clog2(MAX_ENT) - $clog2(MIN_ENT) + 1;
    localparam int TBL_BYTES = MAX_ENT * 4;

    logic [IDX_W:0]      ent_tab [NSIZES];
    logic [ADDR_W-1:0]   msk_tab [NSIZES];
    logic [IDX_W:0]      ent_sel;
    logic [ADDR_W-1:0]   msk_sel;
    logic                sel_ok;
    logic [IDX_W-1:0]    idx;
    logic [SECT_SHIFT-1:0] unused_va_low;

    // one entry count and base mask per legal size code
    for (genvar g = 0; g < NSIZES; g++) begin : g_size
        assign ent_tab[g] = (IDX_W+1)'(MAX_ENT >> g);
        assign msk_tab[g] = ~(ADDR_W'(TBL_BYTES >> g) - ADDR_W'(1));
    end

    // pick the entry count and mask for the requested size code
    always_comb begin
        ent_sel = '0;
        msk_sel = '0;
        sel_ok  = 1'b0;
        for (int k = 0; k < NSIZES; k++) begin
            if (sel_i == SEL_W'(k)) begin
                ent_sel = ent_tab[k];
                msk_sel = msk_tab[k];
                sel_ok  = 1'b1;
            end
        end
    end

    assign idx           = va_i[ADDR_W-1:SECT_SHIFT];
    assign unused_va_low = va_i[SECT_SHIFT-1:0];

    // range check and address formation
    always_comb begin
        in_range_o = sel_ok && ({1'b0, idx} < ent_sel);
        l1_addr_o  = (base_i & msk_sel) | (ADDR_W'(idx) << 2);
    end
endmodule

// File: rtl/xw_desc_decode.sv
// Descriptor decoder for one table level, chosen by LEVEL (1 or 2).
// Level 1: 2'b10 section, 2'b01 pointer to a second-level table.
// Level 2: 2'b10 small page, 2'b01 large page. Anything else faults.
// Purely combinational; assumes desc_i is the word fetched for va_i.
module xw_desc_decode
    import xw_pkg::*;
#(
    parameter int LEVEL = 1
) (
    input  logic [ADDR_W-1:0] desc_i,
    input  logic [ADDR_W-1:0] va_i,
    output desc_res_t         res_o
);
    localparam desc_res_t FAULT_RES = '{kind: DK_FAULT, size: PG_4K, addr: '0};

    if (LEVEL == 1) begin : g_lvl1
        logic [ADDR_W+7:0] unused_l1;
        assign unused_l1 = {desc_i[L2_BASE_SHIFT-1:2], va_i};

        // section leaf or pointer to the second level
        always_comb begin
            unique case (desc_i[1:0])
                2'b10:   res_o = '{kind: DK_LEAF, size: PG_1M,
                                   addr: {desc_i[ADDR_W-1:SECT_SHIFT],
                                          va_i[SECT_SHIFT-1:0]}};
                2'b01:   res_o = '{kind: DK_NEXT, size: PG_4K,
                                   addr: {desc_i[ADDR_W-1:L2_BASE_SHIFT],
                                          va_i[SECT_SHIFT-1:SMALL_SHIFT], 2'b00}};
                default: res_o = FAULT_RES;
            endcase
        end
    end else begin : g_lvl2
        logic [ADDR_W-1:0] unused_l2;
        assign unused_l2 = {desc_i[SMALL_SHIFT-1:2], va_i[ADDR_W-1:SECT_SHIFT],
                            va_i[SECT_SHIFT-1:SECT_SHIFT-2]};

        // small or large page leaf
        always_comb begin
            unique case (desc_i[1:0])
                2'b10:   res_o = '{kind: DK_LEAF, size: PG_4K,
                                   addr: {desc_i[ADDR_W-1:SMALL_SHIFT],
                                          va_i[SMALL_SHIFT-1:0]}};
                2'b01:   res_o = '{kind: DK_LEAF, size: PG_64K,
                                   addr: {desc_i[ADDR_W-1:LARGE_SHIFT],
                                          va_i[LARGE_SHIFT-1:0]}};
                default: res_o = FAULT_RES;
            endcase
        end
    end
endmodule

// File: rtl/xw_walk_ctrl.sv
// Walk sequencer: accepts one lookup, issues at most two single-cycle word
// reads, and emits a one-cycle completion pulse with the result.
// Assumes memory answers every read exactly once; answers arriving while
// idle are ignored.
module xw_walk_ctrl
    import xw_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid_i,
    input  logic [ADDR_W-1:0] req_va_i,
    input  logic              in_range_i,
    input  logic [ADDR_W-1:0] l1_addr_i,
    input  desc_res_t         l1_res_i,
    input  desc_res_t         l2_res_i,
    input  logic              mem_rvalid_i,
    output logic              req_ready_o,
    output logic [ADDR_W-1:0] walk_va_o,
    output logic              mem_req_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic              done_o,
    output logic [ADDR_W-1:0] done_pa_o,
    output logic              done_fault_o,
    output logic [1:0]        done_size_o
);
    localparam desc_res_t FAULT_RES = '{kind: DK_FAULT, size: PG_4K, addr: '0};

    walk_st_e  state;
    logic      fin_go;
    desc_res_t fin_res;

    assign req_ready_o = (state == ST_IDLE);

    // decide whether this cycle ends the walk and with which result
    always_comb begin
        fin_go  = 1'b0;
        fin_res = FAULT_RES;
        unique case (state)
            ST_IDLE: begin
                if (req_valid_i && !in_range_i) fin_go = 1'b1;
            end
            ST_L1_WAIT: begin
                if (mem_rvalid_i && l1_res_i.kind != DK_NEXT) begin
                    fin_go  = 1'b1;
                    fin_res = l1_res_i;
                end
            end
            ST_L2_WAIT: begin
                if (mem_rvalid_i) begin
                    fin_go  = 1'b1;
                    fin_res = l2_res_i;
                end
            end
            default: fin_go = 1'b0;
        endcase
    end

    // state, read request and result registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state        <= ST_IDLE;
            walk_va_o    <= '0;
            mem_req_o    <= 1'b0;
            mem_addr_o   <= '0;
            done_o       <= 1'b0;
            done_pa_o    <= '0;
            done_fault_o <= 1'b0;
            done_size_o  <= 2'd0;
        end else begin
            mem_req_o <= 1'b0;
            done_o    <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (req_valid_i) begin
                        walk_va_o <= req_va_i;
                        if (in_range_i) begin
                            mem_req_o  <= 1'b1;
                            mem_addr_o <= l1_addr_i;
                            state      <= ST_L1_WAIT;
                        end
                    end
                end
                ST_L1_WAIT: begin
                    if (mem_rvalid_i) begin
                        if (l1_res_i.kind == DK_NEXT) begin
                            mem_req_o  <= 1'b1;
                            mem_addr_o <= l1_res_i.addr;
                            state      <= ST_L2_WAIT;
                        end else begin
                            state <= ST_IDLE;
                        end
                    end
                end
                ST_L2_WAIT: begin
                    if (mem_rvalid_i) state <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
            if (fin_go) begin
                done_o       <= 1'b1;
                done_fault_o <= (fin_res.kind != DK_LEAF);
                done_pa_o    <= (fin_res.kind == DK_LEAF) ? fin_res.addr : '0;
                done_size_o  <= (fin_res.kind == DK_LEAF) ? fin_res.size : PG_4K;
            end
        end
    end
endmodule

// File: rtl/xlat_walker.sv
// Top of the two-level translation walker. Wires the first-level locator,
// one decoder per level and the walk sequencer. The read port carries one
// outstanding word read; rdata is only looked at together with rvalid.
module xlat_walker
    import xw_pkg::*;
#(
    parameter int MAX_ENT = 2048,
    parameter int MIN_ENT = 32,
    parameter int SEL_W   = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [31:0]       req_va,
    input  logic [31:0]       req_base,
    input  logic [SEL_W-1:0]  req_sel,
    output logic              mem_req,
    output logic [31:0]       mem_addr,
    input  logic              mem_rvalid,
    input  logic [31:0]       mem_rdata,
    output logic              done,
    output logic [31:0]       done_pa,
    output logic              done_fault,
    output logic [1:0]        done_size
);
    logic              in_range;
    logic [ADDR_W-1:0] l1_addr;
    logic [ADDR_W-1:0] walk_va;
    desc_res_t         l1_res;
    desc_res_t         l2_res;

    xw_l1_locate #(.MAX_ENT(MAX_ENT), .MIN_ENT(MIN_ENT), .SEL_W(SEL_W)) u_locate (
        .va_i       (req_va),
        .base_i     (req_base),
        .sel_i      (req_sel),
        .in_range_o (in_range),
        .l1_addr_o  (l1_addr)
    );

    xw_desc_decode #(.LEVEL(1)) u_dec_l1 (
        .desc_i (mem_rdata),
        .va_i   (walk_va),
        .res_o  (l1_res)
    );

    xw_desc_decode #(.LEVEL(2)) u_dec_l2 (
        .desc_i (mem_rdata),
        .va_i   (walk_va),
        .res_o  (l2_res)
    );

    xw_walk_ctrl u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_valid_i  (req_valid),
        .req_va_i     (req_va),
        .in_range_i   (in_range),
        .l1_addr_i    (l1_addr),
        .l1_res_i     (l1_res),
        .l2_res_i     (l2_res),
        .mem_rvalid_i (mem_rvalid),
        .req_ready_o  (req_ready),
        .walk_va_o    (walk_va),
        .mem_req_o    (mem_req),
        .mem_addr_o   (mem_addr),
        .done_o       (done),
        .done_pa_o    (done_pa),
        .done_fault_o (done_fault),
        .done_size_o  (done_size)
    );
endmodule

// File: rtl/xw_walk_checker.sv
// Protocol and result checks for xlat_walker, attached by bind.
// Keeps its own copy of the accepted virtual address.
module xw_walk_checker #(
    parameter int MAX_ENT = 2048,
    parameter int MIN_ENT = 32,
    parameter int SEL_W   = 3
) (
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid,
    input logic        req_ready,
    input logic [31:0] req_va,
    input logic [SEL_W-1:0] req_sel,
    input logic        mem_req,
    input logic [31:0] mem_addr,
    input logic        done,
    input logic [31:0] done_pa,
    input logic        done_fault,
    input logic [1:0]  done_size
);
    localparam int NSIZES = $clog2(MAX_ENT) - $clog2(MIN_ENT) + 1;

    logic [31:0] va_cap;
    logic        out_of_range;

    // remember the address of the lookup in flight
    always_ff @(posedge clk) begin
        if (!rst_n)                      va_cap <= '0;
        else if (req_valid && req_ready) va_cap <= req_va;
    end

    assign out_of_range = (req_sel >= SEL_W'(NSIZES)) ||
                          ({1'b0, req_va[31:20]} >= 13'(MAX_ENT >> req_sel));

    p_busy_no_ready_r9: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> !req_ready);
    p_req_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |=> !mem_req);
    p_word_addr_r2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> mem_addr[1:0] == 2'b00);
    p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    p_range_fault_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && out_of_range) |=> done && done_fault && !mem_req);
    p_fault_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (done && done_fault) |-> (done_pa == 32'd0 && done_size == 2'd0));
    p_sect_offset_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !done_fault && done_size == 2'd2) |-> done_pa[19:0] == va_cap[19:0]);
    p_small_offset_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !done_fault && done_size == 2'd0) |-> done_pa[11:0] == va_cap[11:0]);
    p_large_offset_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !done_fault && done_size == 2'd1) |-> done_pa[15:0] == va_cap[15:0]);
    p_size_legal_r11: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> done_size != 2'd3);
endmodule

bind xlat_walker xw_walk_checker #(.MAX_ENT(MAX_ENT), .MIN_ENT(MIN_ENT), .SEL_W(SEL_W)) u_walk_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .req_va     (req_va),
    .req_sel    (req_sel),
    .mem_req    (mem_req),
    .mem_addr   (mem_addr),
    .done       (done),
    .done_pa    (done_pa),
    .done_fault (done_fault),
    .done_size  (done_size)
);

// File: tb/xlat_walker_test.sv
// Self-checking bench: vector table walked by one loop, then directed cases.
module xlat_walker_test;
    localparam int CLK_P   = 10;
    localparam int MEM_LAT = 2;

    typedef struct packed {
        logic [31:0] va;
        logic [31:0] base;
        logic [2:0]  sel;
        logic        fault;
        logic [1:0]  size;
        logic [31:0] pa;
        logic [1:0]  reads;
        logic [31:0] a0;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t VECS [NV] = '{
        '{32'h0031_2345, 32'h0001_0000, 3'd0, 1'b0, 2'd2, 32'h8A51_2345, 2'd1, 32'h0001_000C},
        '{32'h0040_5ABC, 32'h0001_0000, 3'd0, 1'b0, 2'd0, 32'h1234_5ABC, 2'd2, 32'h0001_0010},
        '{32'h0042_7ABC, 32'h0001_0000, 3'd0, 1'b0, 2'd1, 32'h7788_7ABC, 2'd2, 32'h0001_0010},
        '{32'h0042_F001, 32'h0001_0000, 3'd0, 1'b0, 2'd1, 32'h7788_F001, 2'd2, 32'h0001_0010},
        '{32'h0040_6000, 32'h0001_0000, 3'd0, 1'b1, 2'd0, 32'h0000_0000, 2'd2, 32'h0001_0010},
        '{32'h0050_0000, 32'h0001_0000, 3'd0, 1'b1, 2'd0, 32'h0000_0000, 2'd1, 32'h0001_0014},
        '{32'h0060_0000, 32'h0001_0000, 3'd0, 1'b1, 2'd0, 32'h0000_0000, 2'd1, 32'h0001_0018},
        '{32'h01FF_FFFF, 32'h0003_0000, 3'd6, 1'b0, 2'd2, 32'hABCF_FFFF, 2'd1, 32'h0003_007C},
        '{32'h01FF_FFFF, 32'h0003_0055, 3'd6, 1'b0, 2'd2, 32'hABCF_FFFF, 2'd1, 32'h0003_007C},
        '{32'h0200_0000, 32'h0003_0000, 3'd6, 1'b1, 2'd0, 32'h0000_0000, 2'd0, 32'h0000_0000},
        '{32'h8000_0000, 32'h0001_0000, 3'd0, 1'b1, 2'd0, 32'h0000_0000, 2'd0, 32'h0000_0000},
        '{32'h0031_2345, 32'h0001_0000, 3'd7, 1'b1, 2'd0, 32'h0000_0000, 2'd0, 32'h0000_0000},
        '{32'h0FF1_2345, 32'h0004_0200, 3'd3, 1'b0, 2'd2, 32'h5551_2345, 2'd1, 32'h0004_03FC},
        '{32'h1000_0000, 32'h0004_0000, 3'd3, 1'b1, 2'd0, 32'h0000_0000, 2'd0, 32'h0000_0000}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_va = '0;
    logic [31:0] req_base = '0;
    logic [2:0]  req_sel = '0;
    logic        mem_req;
    logic [31:0] mem_addr;
    logic        mem_rvalid;
    logic [31:0] mem_rdata;
    logic        done;
    logic [31:0] done_pa;
    logic        done_fault;
    logic [1:0]  done_size;

    logic        rv_mem = 1'b0;
    logic        rv_extra = 1'b0;
    logic [31:0] rd_mem = '0;
    int          rd_cnt = 0;
    logic [31:0] rd_hold = '0;
    int          reads_total = 0;
    logic [31:0] addr_log [int];
    logic [31:0] mem_words [logic [31:0]];

    int checks = 0;
    int fails  = 0;

    assign mem_rvalid = rv_mem | rv_extra;
    assign mem_rdata  = rd_mem;

    always #(CLK_P/2) clk = ~clk;

    xlat_walker uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_va(req_va), .req_base(req_base), .req_sel(req_sel),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_rvalid(mem_rvalid),
        .mem_rdata(mem_rdata), .done(done), .done_pa(done_pa),
        .done_fault(done_fault), .done_size(done_size)
    );

    function automatic logic [31:0] mem_rd(input logic [31:0] a);
        if (mem_words.exists(a)) return mem_words[a];
        return 32'h0;
    endfunction

    // memory model: fixed latency, one answer per request
    always @(negedge clk) begin
        rv_mem <= 1'b0;
        if (rd_cnt == 1) begin
            rv_mem <= 1'b1;
            rd_mem <= mem_rd(rd_hold);
        end
        if (rd_cnt != 0) rd_cnt <= rd_cnt - 1;
        if (mem_req) begin
            rd_cnt <= MEM_LAT;
            rd_hold <= mem_addr;
            addr_log[reads_total] = mem_addr;
            reads_total <= reads_total + 1;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // run one lookup; poke drives a second request while busy (R9)
    task automatic walk(input vec_t v, input bit poke, input int vi);
        int snap;
        int last_rv;
        int done_step;
        logic [31:0] pa;
        logic f;
        logic [1:0] sz;
        @(negedge clk);
        snap = reads_total;
        req_valid = 1'b1; req_va = v.va; req_base = v.base; req_sel = v.sel;
        last_rv = 0; done_step = -1; pa = '0; f = 1'b0; sz = '0;
        for (int s = 1; s < 100 && done_step < 0; s++) begin
            @(negedge clk); #1;
            req_valid = 1'b0;
            if (poke && (s == 2 || s == 3)) begin
                chk(req_ready == 1'b0, "R9 ready low while busy", {31'd0, req_ready}, 32'd0);
                req_valid = 1'b1; req_va = 32'h0031_2345; req_sel = 3'd0;
            end
            if (mem_rvalid) last_rv = s;
            if (done) begin
                done_step = s; pa = done_pa; f = done_fault; sz = done_size;
            end
        end
        req_valid = 1'b0;
        chk(done_step > 0, $sformatf("R11 done seen v%0d", vi), done_step, 1);
        chk(f == v.fault, $sformatf("R8 fault flag v%0d", vi), {31'd0, f}, {31'd0, v.fault});
        chk(pa == v.pa, $sformatf("R4/R6/R7 pa v%0d", vi), pa, v.pa);
        chk(sz == v.size, $sformatf("R4/R6/R7 size v%0d", vi), {30'd0, sz}, {30'd0, v.size});
        chk(reads_total - snap == int'(v.reads), $sformatf("R3/R5 read count v%0d", vi),
            reads_total - snap, v.reads);
        if (v.reads != 0)
            chk(addr_log[snap] == v.a0, $sformatf("R2 first read addr v%0d", vi),
                addr_log[snap], v.a0);
        if (v.reads == 2)
            chk(addr_log[snap+1] == (32'h0002_0400 | {22'd0, v.va[19:12], 2'b00}),
                $sformatf("R5 second read addr v%0d", vi), addr_log[snap+1],
                32'h0002_0400 | {22'd0, v.va[19:12], 2'b00});
        chk(done_step == ((v.reads == 0) ? 1 : last_rv + 1),
            $sformatf("R11 done timing v%0d", vi), done_step,
            (v.reads == 0) ? 1 : last_rv + 1);
        @(negedge clk); #1;
        chk(done == 1'b0, $sformatf("R11 single pulse v%0d", vi), {31'd0, done}, 32'd0);
    endtask

    initial begin
        #(CLK_P * 150000);
        fails++;
        checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", fails, checks);
        $finish;
    end

    initial begin
        int seen;
        mem_words[32'h0001_000C] = 32'h8A50_0C02;
        mem_words[32'h0001_0010] = 32'h0002_0401;
        mem_words[32'h0001_0018] = 32'h00F0_0003;
        mem_words[32'h0002_0414] = 32'h1234_5FF2;
        for (int k = 0; k < 16; k++)
            mem_words[32'h0002_0480 + 32'(k*4)] = 32'h7788_0FF1;
        mem_words[32'h0003_007C] = 32'hABC0_0002;
        mem_words[32'h0004_03FC] = 32'h5550_0002;

        repeat (3) @(negedge clk);
        #1;
        chk(req_ready == 1'b1 && done == 1'b0 && mem_req == 1'b0, "R1 reset state",
            {29'd0, req_ready, done, mem_req}, 32'h4);
        @(negedge clk);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) walk(VECS[i], 1'b0, i);

        // R9: request presented while busy is ignored
        walk(VECS[1], 1'b1, 100);
        repeat (3) begin
            @(negedge clk); #1;
            chk(done == 1'b0 && mem_req == 1'b0, "R9 no second walk", {30'd0, done, mem_req}, 0);
        end

        // R10: stray read data while idle
        @(negedge clk); #1;
        rv_extra = 1'b1;
        @(negedge clk); #1;
        rv_extra = 1'b0;
        seen = 0;
        repeat (4) begin
            @(negedge clk); #1;
            if (done || mem_req) seen++;
        end
        chk(seen == 0, "R10 stray rvalid ignored", seen, 0);
        walk(VECS[0], 1'b0, 101);

        // R1: reset in the middle of a walk, late answer ignored
        @(negedge clk);
        req_valid = 1'b1; req_va = VECS[1].va; req_base = VECS[1].base; req_sel = 3'd0;
        @(negedge clk); #1;
        req_valid = 1'b0;
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        #1;
        chk(req_ready == 1'b1 && done == 1'b0 && mem_req == 1'b0, "R1 reset mid-walk",
            {29'd0, req_ready, done, mem_req}, 32'h4);
        rst_n = 1'b1;
        seen = 0;
        repeat (6) begin
            @(negedge clk); #1;
            if (done) seen++;
        end
        chk(seen == 0, "R1 late answer after reset ignored", seen, 0);
        walk(VECS[2], 1'b0, 102);

        $display("Result: errors=%0d of %0d checks", fails, checks);
        $finish;
    end
endmodule